// File: doc/BRIEF.md
# Ternary Bit-Plane Dot Product Unit

This block takes two vectors of ternary numbers (-1, 0, +1) and produces their dot product as a signed integer in one pass. Each vector arrives as a pair of bit masks. One mask marks the elements that are +1 and the other marks the elements that are -1. The unit forms the element products with bitwise logic only. It counts the set bits in the positive product mask and in the negative product mask, and it returns their difference along with both product masks.

Operands enter through a valid/ready handshake. The popcount runs as a two-stage pipeline, so a result leaves the unit two cycles after its operands were accepted. When the consumer stops taking results, the whole pipeline freezes. Any element whose two mask bits are both set is malformed. The unit treats such an element as zero and latches a sticky error indicator. The indicator is a two-state machine: ERR_CLEAR moves to ERR_LATCHED on the transition "accept malformed operand". ERR_LATCHED has only the transition "hold", and the machine leaves it only through reset.

Top module: `tern_dot_unit`

## Requirements
- R1: Element i of an operand is +1 when only bit i of its positive mask is set, -1 when only bit i of its negative mask is set, and 0 when neither bit is set.
- R2: Bit i of out_pos is set exactly when the product of element i of A and element i of B is +1, that is (Ap & Bp) | (An & Bn) on cleaned masks.
- R3: Bit i of out_neg is set exactly when that product is -1, that is (An & Bp) | (Ap & Bn) on cleaned masks.
- R4: out_sum is the two's complement value popcount(out_pos) - popcount(out_neg). It is SW = clog2(W+1)+1 bits wide (8 bits for W = 64) and always lies in the range -W to +W.
- R5: An element with both mask bits set in an operand counts as 0. It sets no bit in out_pos or out_neg and adds nothing to out_sum.
- R6: err_flag is low after reset. It goes high in the cycle after an accepted operand pair that contains a malformed element, and it stays high until the next reset.
- R7: While out_ready is held high, operands accepted in cycle c give out_valid high in cycle c+2 and not in cycle c+1.
- R8: While out_ready is high, in_ready is high in every cycle, and a new operand pair can be accepted every cycle with one result delivered per cycle, in order.
- R9: While out_valid is high and out_ready is low, in_ready is low and out_sum, out_pos and out_neg hold their values. No result is lost or duplicated when the stall ends.
- R10: During and just after reset, out_valid and err_flag are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Unit can take an operand pair |
| a_pos | input | W | Operand A, +1 mask |
| a_neg | input | W | Operand A, -1 mask |
| b_pos | input | W | Operand B, +1 mask |
| b_neg | input | W | Operand B, -1 mask |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_sum | output | SW | Signed dot product |
| out_pos | output | W | Product +1 mask |
| out_neg | output | W | Product -1 mask |
| err_flag | output | 1 | Sticky malformed-element indicator |

## Verification
All 81 legal code combinations of two elements per operand are swept at both ends of the word. This separates the positive-mask terms from the negative-mask terms and catches swapped or misplaced bits. The full-word patterns (all +1 against all +1, all +1 against all -1, alternating signs) drive the sum to +W, -W and zero, which tests the sum width and the sign handling. A sweep over all 256 codes of two elements, the malformed code included, shows whether malformed elements leak into the product masks and whether the sticky flag sets and then clears on reset. Random streams with an irregular out_ready pattern tell a correct whole-pipeline stall apart from a stall that drops or repeats results.

// File: rtl/tern_pkg.sv
package tern_pkg;
    typedef enum logic {
        ERR_CLEAR   = 1'b0,
        ERR_LATCHED = 1'b1
    } err_state_t;
endpackage

// File: rtl/tern_plane_mul.sv
module tern_plane_mul #(
    parameter int W = 64
) (
    input  logic [W-1:0] a_pos,
    input  logic [W-1:0] a_neg,
    input  logic [W-1:0] b_pos,
    input  logic [W-1:0] b_neg,
    output logic [W-1:0] p_pos,
    output logic [W-1:0] p_neg,
    output logic         malformed
);
    logic [W-1:0] ap, an, bp, bn;

    // R5: both bits set means zero, so strip such elements from both masks
    always_comb begin
        ap = a_pos & ~a_neg;
        an = a_neg & ~a_pos;
        bp = b_pos & ~b_neg;
        bn = b_neg & ~b_pos;
    end

    // R2 / R3: sign agreement gives +1, disagreement gives -1
    always_comb begin
        p_pos = (ap & bp) | (an & bn);
        p_neg = (an & bp) | (ap & bn);
    end

    always_comb malformed = |(a_pos & a_neg) | |(b_pos & b_neg);
endmodule

// File: rtl/tern_popcnt_stage.sv
module tern_popcnt_stage #(
    parameter int W     = 64,
    parameter int CHUNK = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic [W-1:0]           bits,
    output logic [$clog2(W+1)-1:0] total
);
    localparam int NCH = W / CHUNK;
    localparam int PW  = $clog2(CHUNK + 1);
    localparam int CW  = $clog2(W + 1);

    logic [NCH*PW-1:0] part_flat;

    for (genvar g = 0; g < NCH; g++) begin : gen_chunk
        logic [PW-1:0] cnt_d;
        logic [PW-1:0] cnt_q;

        always_comb begin
            cnt_d = '0;
            for (int k = 0; k < CHUNK; k++) begin
                cnt_d = cnt_d + {{(PW-1){1'b0}}, bits[g*CHUNK + k]};
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n)  cnt_q <= '0;
            else if (en) cnt_q <= cnt_d;
        end

        assign part_flat[g*PW +: PW] = cnt_q;
    end

    always_comb begin
        total = '0;
        for (int k = 0; k < NCH; k++) begin
            total = total + {{(CW-PW){1'b0}}, part_flat[k*PW +: PW]};
        end
    end

    // R4: the partial counts never add up to more than the word holds
    a_r4_total_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(total) <= W);
endmodule

// File: rtl/tern_dot_unit.sv
module tern_dot_unit
    import tern_pkg::*;
#(
    parameter int W     = 64,
    parameter int CHUNK = 8,
    parameter int SW    = $clog2(W + 1) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [W-1:0]  a_pos,
    input  logic [W-1:0]  a_neg,
    input  logic [W-1:0]  b_pos,
    input  logic [W-1:0]  b_neg,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [SW-1:0] out_sum,
    output logic [W-1:0]  out_pos,
    output logic [W-1:0]  out_neg,
    output logic          err_flag
);
    localparam int CW = $clog2(W + 1);

    logic          advance;
    logic          accept;
    logic [W-1:0]  p_pos, p_neg;
    logic          malformed;
    logic          s1_vld;
    logic [W-1:0]  s1_pos, s1_neg;
    logic [CW-1:0] pos_tot, neg_tot;
    err_state_t    err_q, err_d;

    // whole pipeline moves together or not at all
    always_comb begin
        advance  = out_ready || !out_valid;
        in_ready = advance;
        accept   = in_valid && advance;
    end

    tern_plane_mul #(.W(W)) mul_i (
        .a_pos(a_pos), .a_neg(a_neg), .b_pos(b_pos), .b_neg(b_neg),
        .p_pos(p_pos), .p_neg(p_neg), .malformed(malformed)
    );

    tern_popcnt_stage #(.W(W), .CHUNK(CHUNK)) cnt_pos_i (
        .clk(clk), .rst_n(rst_n), .en(advance), .bits(p_pos), .total(pos_tot)
    );

    tern_popcnt_stage #(.W(W), .CHUNK(CHUNK)) cnt_neg_i (
        .clk(clk), .rst_n(rst_n), .en(advance), .bits(p_neg), .total(neg_tot)
    );

    // stage 1: product masks alongside the partial counts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s1_pos <= '0;
            s1_neg <= '0;
        end else if (advance) begin
            s1_vld <= in_valid;
            s1_pos <= p_pos;
            s1_neg <= p_neg;
        end
    end

    // stage 2: final difference, registered at the output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sum   <= '0;
            out_pos   <= '0;
            out_neg   <= '0;
        end else if (advance) begin
            out_valid <= s1_vld;
            out_sum   <= {{(SW-CW){1'b0}}, pos_tot} - {{(SW-CW){1'b0}}, neg_tot};
            out_pos   <= s1_pos;
            out_neg   <= s1_neg;
        end
    end

    // sticky error machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= ERR_CLEAR;
        else        err_q <= err_d;
    end

    // sticky error machine: next state and output
    always_comb begin
        err_d    = err_q;
        err_flag = 1'b0;
        unique case (err_q)
            ERR_CLEAR: begin
                if (accept && malformed) err_d = ERR_LATCHED;
            end
            ERR_LATCHED: begin
                err_flag = 1'b1;
            end
        endcase
    end

    a_r4_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($signed(out_sum) >= -W && $signed(out_sum) <= W));

    a_r4_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_neg == '0) |-> !out_sum[SW-1]);

    a_r5_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_pos & out_neg) == '0));

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    a_r8_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sum)
                                       && $stable(out_pos) && $stable(out_neg)));
endmodule

// File: tb/tern_dot_unit_tb_top.sv
module tern_dot_unit_tb_top;
    localparam int W  = 64;
    localparam int SW = $clog2(W + 1) + 1;
    localparam int SBD = 512;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid, in_ready, out_valid, out_ready, err_flag;
    logic [W-1:0]  a_pos, a_neg, b_pos, b_neg, out_pos, out_neg;
    logic [SW-1:0] out_sum;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    logic [SW-1:0] sb_sum [SBD];
    logic [W-1:0]  sb_pos [SBD];
    logic [W-1:0]  sb_neg [SBD];
    int wr_p = 0;
    int rd_p = 0;
    bit            prev_stall = 1'b0;
    logic [SW-1:0] st_sum;
    logic [W-1:0]  st_pos, st_neg;

    always #2.5 clk = ~clk;

    tern_dot_unit #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .a_pos(a_pos), .a_neg(a_neg), .b_pos(b_pos), .b_neg(b_neg),
        .out_valid(out_valid), .out_ready(out_ready), .out_sum(out_sum),
        .out_pos(out_pos), .out_neg(out_neg), .err_flag(err_flag)
    );

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int elem(input logic p, input logic n);
        if (p && !n) return 1;
        if (n && !p) return -1;
        return 0;
    endfunction

    task automatic push_exp(input logic [W-1:0] ap, an, bp, bn);
        int s = 0;
        logic [W-1:0] ep = '0;
        logic [W-1:0] en = '0;
        for (int i = 0; i < W; i++) begin
            int pr = elem(ap[i], an[i]) * elem(bp[i], bn[i]);
            if (pr == 1)  ep[i] = 1'b1;
            if (pr == -1) en[i] = 1'b1;
            s += pr;
        end
        sb_sum[wr_p % SBD] = SW'(s);
        sb_pos[wr_p % SBD] = ep;
        sb_neg[wr_p % SBD] = en;
        wr_p++;
    endtask

    task automatic step(input logic v, input logic [W-1:0] ap, an, bp, bn,
                        input logic rdy);
        @(negedge clk);
        in_valid  = v;
        a_pos = ap; a_neg = an; b_pos = bp; b_neg = bn;
        out_ready = rdy;
        #1;
        if (out_valid && !out_ready) begin
            check(!in_ready, "R9 in_ready low in stall", W'(in_ready), '0);
            if (prev_stall) begin
                check(out_sum == st_sum, "R9 sum held", W'(out_sum), W'(st_sum));
                check(out_pos == st_pos && out_neg == st_neg, "R9 masks held",
                      out_pos, st_pos);
            end
            prev_stall = 1'b1;
            st_sum = out_sum; st_pos = out_pos; st_neg = out_neg;
        end else begin
            prev_stall = 1'b0;
        end
        if (out_valid && out_ready) begin
            if (rd_p >= wr_p) begin
                check(1'b0, "R9 extra result", W'(rd_p), W'(wr_p));
            end else begin
                check(out_pos == sb_pos[rd_p % SBD], "R2 out_pos", out_pos, sb_pos[rd_p % SBD]);
                check(out_neg == sb_neg[rd_p % SBD], "R3 out_neg", out_neg, sb_neg[rd_p % SBD]);
                check(out_sum == sb_sum[rd_p % SBD], "R4 out_sum", W'(out_sum), W'(sb_sum[rd_p % SBD]));
                rd_p++;
            end
        end
        if (in_valid && in_ready) push_exp(ap, an, bp, bn);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, '0, '0, '0, 1'b1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
        a_pos = '0; a_neg = '0; b_pos = '0; b_neg = '0;
        repeat (3) @(negedge clk);
        #1;
        check(!out_valid, "R10 out_valid in reset", W'(out_valid), '0);
        check(!err_flag, "R10 err_flag in reset", W'(err_flag), '0);
        check(in_ready, "R10 in_ready in reset", W'(in_ready), 1);
        rst_n = 1'b1;
        wr_p = 0; rd_p = 0; prev_stall = 1'b0;
    endtask

    function automatic logic [W-1:0] rnd();
        return {$urandom, $urandom};
    endfunction

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin : main
        do_reset();
        idle(1);
        check(!out_valid && !err_flag, "R10 after release", W'({out_valid, err_flag}), '0);

        // R1/R2/R3: all legal code pairs on two elements, low end and high end
        for (int pos = 0; pos < 2; pos++) begin
            for (int c = 0; c < 81; c++) begin
                logic [W-1:0] ap = '0, an = '0, bp = '0, bn = '0;
                int cc = c;
                int lo = (pos == 0) ? 0 : W - 2;
                for (int e = 0; e < 4; e++) begin
                    int t = cc % 3;
                    cc = cc / 3;
                    if (e < 2) begin
                        ap[lo + e] = (t == 1); an[lo + e] = (t == 2);
                    end else begin
                        bp[lo + e - 2] = (t == 1); bn[lo + e - 2] = (t == 2);
                    end
                end
                step(1'b1, ap, an, bp, bn, 1'b1);
            end
        end

        // R4: extremes of the sum
        step(1'b1, '1, '0, '1, '0, 1'b1);
        step(1'b1, '1, '0, '0, '1, 1'b1);
        step(1'b1, '0, '1, '0, '1, 1'b1);
        step(1'b1, {(W/2){2'b01}}, {(W/2){2'b10}}, '1, '0, 1'b1);
        step(1'b1, '0, '0, '1, '0, 1'b1);

        // R8: random legal burst with out_ready high
        for (int i = 0; i < 300; i++) begin
            logic [W-1:0] x = rnd(), y = rnd(), u = rnd(), z = rnd();
            step(1'b1, x & y, x & ~y, u & z, u & ~z, 1'b1);
            check(in_ready, "R8 in_ready during burst", W'(in_ready), 1);
        end
        idle(4);
        check(rd_p == wr_p, "R8 all results delivered", W'(rd_p), W'(wr_p));
        check(!err_flag, "R6 no error on legal traffic", W'(err_flag), '0);

        // R7: latency of two cycles
        step(1'b1, '1, '0, '1, '0, 1'b1);
        step(1'b0, '0, '0, '0, '0, 1'b1);
        check(!out_valid, "R7 not valid at c+1", W'(out_valid), '0);
        step(1'b0, '0, '0, '0, '0, 1'b1);
        check(out_valid, "R7 valid at c+2", W'(out_valid), 1);
        idle(2);

        // R9: long stall then irregular backpressure
        for (int i = 0; i < 8; i++) begin
            logic [W-1:0] x = rnd(), y = rnd();
            step(1'b1, x & y, x & ~y, y, ~y, 1'b0);
        end
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] x = rnd(), y = rnd(), u = rnd(), z = rnd();
            step(($urandom % 3) != 0, x & y, x & ~y, u & z, u & ~z, ($urandom % 2) == 1);
        end
        idle(6);
        check(rd_p == wr_p, "R9 no lost results", W'(rd_p), W'(wr_p));
        check(!err_flag, "R6 still clear", W'(err_flag), '0);

        // R5/R6: every code including malformed on two elements per operand
        for (int c = 0; c < 256; c++) begin
            logic [W-1:0] ap = '0, an = '0, bp = '0, bn = '0;
            ap[0] = c[0]; an[0] = c[1]; ap[W-1] = c[2]; an[W-1] = c[3];
            bp[0] = c[4]; bn[0] = c[5]; bp[W-1] = c[6]; bn[W-1] = c[7];
            step(1'b1, ap, an, bp, bn, 1'b1);
            if (c == 3) begin
                step(1'b0, '0, '0, '0, '0, 1'b1);
                check(err_flag, "R6 set after malformed", W'(err_flag), 1);
            end
        end
        idle(4);
        check(rd_p == wr_p, "R5 results delivered", W'(rd_p), W'(wr_p));
        check(err_flag, "R6 sticky", W'(err_flag), 1);
        // R5: malformed-only operand gives zero
        step(1'b1, '1, '1, '1, '0, 1'b1);
        idle(3);

        // R6: reset clears the flag
        do_reset();
        idle(1);
        check(!err_flag, "R6 cleared by reset", W'(err_flag), '0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule